// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside an 8-bit CPU that takes interrupts in vectored mode. It watches up to eight request lines and records each rising edge in a sticky pending bit. It ranks the pending sources and raises either the maskable interrupt request or the non-maskable request. During a maskable acknowledge it drives the low byte of the handler address. The CPU's own page register supplies the high byte, and a jump table in memory then branches to the handler.

Each source has one byte-wide action register, and that byte does three jobs. A value of zero disables the source. A value of one sends the source to the non-maskable line, whose handler sits at a fixed low address in the page. Any value from 2 up is the vector byte itself. The same number sets the priority: the smallest vector wins, and on a tie the lower source index wins.

Nesting has two levels. Once a maskable acknowledge is taken, an in-service flag holds off every further maskable request until the CPU pulses the return strobe. The non-maskable path ignores this flag.

Top module: `vpic_top`

## Requirements
- R1: After reset, all pending bits and all action registers read 0, and intReq and nmiReq are low.
- R2: The action register of source i is written and read back at I/O address 0x08+i. Address 0x07 reads the pending bits, with source i in bit i.
- R3: A 0-to-1 transition on irqIn[i] sets pending bit i if that source's action is nonzero. The bit stays set after the line falls. A line held high does not set the bit again once it has been cleared.
- R4: When a source's action is 0, an edge on its line leaves its pending bit at 0 and raises no request.
- R5: A pending source with action 1 raises nmiReq and never intReq. An nmiAck pulse clears the pending bit of the lowest-indexed such source.
- R6: When any pending source has an action of 2 or more, vecOut equals the smallest such action. On a tie, the lower source index wins.
- R7: An intAck pulse while intReq is high clears the winning source's pending bit and sets the in-service flag. While the flag is set, intReq stays low.
- R8: A retStrobe pulse clears the in-service flag, and maskable sources still pending raise intReq again.
- R9: nmiReq follows pending non-maskable sources whether or not a maskable interrupt is in service.
- R10: Writing to address 0x07 clears every pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC | Request lines, sampled for rising edges |
| ioAddr | input | 8 | I/O register address |
| ioWrEn | input | 1 | I/O write strobe |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data for ioAddr |
| intReq | output | 1 | Maskable interrupt request |
| nmiReq | output | 1 | Non-maskable interrupt request |
| vecOut | output | 8 | Low vector byte of the winning maskable source |
| intAck | input | 1 | Maskable acknowledge strobe |
| nmiAck | input | 1 | Non-maskable acknowledge strobe |
| retStrobe | input | 1 | Return-from-interrupt strobe |

## Verification
Every source is tried alone with small, mid-range and maximum action values. This separates the vector path from the enable path and from the per-source address decode. All 56 ordered pairs of sources are then raised together with computed action values, some of them equal. These runs show whether ranking is by value or by index, and how ties are broken. Each pair is carried through acknowledge, hold-off and return. Mixed runs of non-maskable and maskable sources, a set of disabled sources, and partial clear writes show that the two paths and the clear mask stay independent.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned MAX_SRC = 8;

  typedef struct packed {
    logic [MAX_SRC-1:0] ackClr;
    logic [MAX_SRC-1:0] nmiClr;
    logic               setInSvc;
    logic               clrInSvc;
  } ctrlStrobes_t;
endpackage

// File: rtl/vpic_datapath.sv
module vpic_datapath
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 8,
  parameter logic [7:0]  PEND_ADDR = 8'h07,
  parameter logic [7:0]  ACT_BASE  = 8'h08
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqIn,
  input  logic [7:0]           ioAddr,
  input  logic                 ioWrEn,
  input  logic [7:0]           ioWrData,
  input  ctrlStrobes_t         strobes,
  output logic [7:0]           ioRdData,
  output logic [NUM_SRC-1:0]   pendingBits,
  output logic [NUM_SRC*8-1:0] actionFlat
);
  logic [NUM_SRC-1:0] irqPrev;
  logic               pendWrite;

  assign pendWrite = ioWrEn && (ioAddr == PEND_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqIn;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [7:0] actionReg;
    logic       riseSeen;
    logic       clrHit;

    assign riseSeen = irqIn[g] && !irqPrev[g];
    assign clrHit   = strobes.ackClr[g] || strobes.nmiClr[g] ||
                      (pendWrite && ioWrData[g]);

    always_ff @(posedge clk) begin
      if (!rstN)
        actionReg <= '0;
      else if (ioWrEn && ioAddr == 8'(ACT_BASE + g))
        actionReg <= ioWrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        pendingBits[g] <= 1'b0;
      else if (riseSeen && actionReg != 8'h00)
        pendingBits[g] <= 1'b1;
      else if (clrHit)
        pendingBits[g] <= 1'b0;
    end

    assign actionFlat[g*8 +: 8] = actionReg;
  end

  always_comb begin
    ioRdData = '0;
    if (ioAddr == PEND_ADDR) ioRdData[NUM_SRC-1:0] = pendingBits;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ioAddr == 8'(ACT_BASE + i)) ioRdData = actionFlat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/vpic_control.sv
module vpic_control
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   pendingBits,
  input  logic [NUM_SRC*8-1:0] actionFlat,
  input  logic                 intAck,
  input  logic                 nmiAck,
  input  logic                 retStrobe,
  output logic                 intReq,
  output logic                 nmiReq,
  output logic [7:0]           vecOut,
  output logic                 inService,
  output ctrlStrobes_t         strobes
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             mskFound;
  logic [IDX_W-1:0] mskIdx;
  logic [7:0]       mskVal;
  logic             nmiFound;
  logic [IDX_W-1:0] nmiIdx;
  logic             takeInt;

  always_comb begin
    mskFound = 1'b0;
    mskIdx   = '0;
    mskVal   = 8'hFF;
    nmiFound = 1'b0;
    nmiIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendingBits[i] && actionFlat[i*8 +: 8] > 8'h01 &&
          (!mskFound || actionFlat[i*8 +: 8] < mskVal)) begin
        mskFound = 1'b1;
        mskIdx   = IDX_W'(i);
        mskVal   = actionFlat[i*8 +: 8];
      end
      if (pendingBits[i] && actionFlat[i*8 +: 8] == 8'h01 && !nmiFound) begin
        nmiFound = 1'b1;
        nmiIdx   = IDX_W'(i);
      end
    end
  end

  assign intReq  = mskFound && !inService;
  assign nmiReq  = nmiFound;
  assign vecOut  = mskFound ? mskVal : 8'h00;
  assign takeInt = intAck && intReq;

  always_comb begin
    strobes          = '0;
    strobes.setInSvc = takeInt;
    strobes.clrInSvc = retStrobe;
    if (takeInt)             strobes.ackClr = MAX_SRC'(1) << mskIdx;
    if (nmiAck && nmiFound)  strobes.nmiClr = MAX_SRC'(1) << nmiIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 inService <= 1'b0;
    else if (strobes.setInSvc) inService <= 1'b1;
    else if (strobes.clrInSvc) inService <= 1'b0;
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 8,
  parameter logic [7:0]  PEND_ADDR = 8'h07,
  parameter logic [7:0]  ACT_BASE  = 8'h08
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [7:0]         ioAddr,
  input  logic               ioWrEn,
  input  logic [7:0]         ioWrData,
  output logic [7:0]         ioRdData,
  output logic               intReq,
  output logic               nmiReq,
  output logic [7:0]         vecOut,
  input  logic               intAck,
  input  logic               nmiAck,
  input  logic               retStrobe
);
  logic [NUM_SRC-1:0]   pendingBits;
  logic [NUM_SRC*8-1:0] actionFlat;
  logic                 inService;
  ctrlStrobes_t         strobes;

  vpic_datapath #(
    .NUM_SRC(NUM_SRC), .PEND_ADDR(PEND_ADDR), .ACT_BASE(ACT_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ioAddr(ioAddr),
    .ioWrEn(ioWrEn), .ioWrData(ioWrData), .strobes(strobes),
    .ioRdData(ioRdData), .pendingBits(pendingBits), .actionFlat(actionFlat)
  );

  vpic_control #(.NUM_SRC(NUM_SRC)) u_ctl (
    .clk(clk), .rstN(rstN), .pendingBits(pendingBits), .actionFlat(actionFlat),
    .intAck(intAck), .nmiAck(nmiAck), .retStrobe(retStrobe),
    .intReq(intReq), .nmiReq(nmiReq), .vecOut(vecOut),
    .inService(inService), .strobes(strobes)
  );
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
  parameter int unsigned NUM_SRC   = 8,
  parameter logic [7:0]  PEND_ADDR = 8'h07
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [7:0]         ioAddr,
  input logic               ioWrEn,
  input logic [7:0]         ioWrData,
  input logic               intReq,
  input logic               nmiReq,
  input logic [7:0]         vecOut,
  input logic               intAck,
  input logic               retStrobe,
  input logic [NUM_SRC-1:0] pendingBits,
  input logic               inService
);
  // R7
  ack_holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck && intReq && !retStrobe |=> !intReq);

  // R6
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> vecOut > 8'h01);

  // R8
  return_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe && !(intAck && intReq) |=> !inService);

  // R10
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioWrEn && ioAddr == PEND_ADDR && (&ioWrData[NUM_SRC-1:0]) && irqIn == '0
    |=> pendingBits == '0);

  // R5
  nmi_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> pendingBits != '0);
endmodule

bind vpic_top vpic_checker #(.NUM_SRC(NUM_SRC), .PEND_ADDR(PEND_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
  .ioWrData(ioWrData), .intReq(intReq), .nmiReq(nmiReq), .vecOut(vecOut),
  .intAck(intAck), .retStrobe(retStrobe), .pendingBits(pendingBits),
  .inService(inService)
);

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic [7:0] ioAddr = '0;
  logic       ioWrEn = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic       intReq, nmiReq;
  logic [7:0] vecOut;
  logic       intAck = 1'b0, nmiAck = 1'b0, retStrobe = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vpic_top u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .intReq(intReq), .nmiReq(nmiReq),
    .vecOut(vecOut), .intAck(intAck), .nmiAck(nmiAck), .retStrobe(retStrobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    ioAddr = a; #1; d = ioRdData;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic clearActs();
    for (int k = 0; k < 8; k++) wr(8'(8 + k), 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 intReq", intReq, 0);
    chk("R1 nmiReq", nmiReq, 0);
    for (int i = 0; i < 9; i++) begin
      rd(8'(7 + i), d); chk("R1 register", d, 0);
    end

    // R2 action readback
    for (int i = 0; i < 8; i++) wr(8'(8 + i), 8'(8'h20 + i * 3));
    for (int i = 0; i < 8; i++) begin
      rd(8'(8 + i), d); chk("R2 action readback", d, 32'(8'h20 + i * 3));
    end

    // R4 disabled sources
    clearActs();
    irqIn = 8'hFF; @(negedge clk);
    rd(8'h07, d); chk("R4 pending", d, 0);
    chk("R4 intReq", intReq, 0);
    chk("R4 nmiReq", nmiReq, 0);
    irqIn = 8'h00; @(negedge clk);

    // R3 R6 R10 single source sweep
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 3; v++) begin
        logic [7:0] val;
        val = (v == 0) ? 8'h02 : (v == 1) ? 8'h66 : 8'hFF;
        clearActs();
        wr(8'(8 + i), val);
        irqIn = 8'(1 << i); @(negedge clk);
        irqIn = 8'h00; @(negedge clk); @(negedge clk);
        rd(8'h07, d); chk("R3 sticky pending", d, 32'(1 << i));
        chk("R6 single intReq", intReq, 1);
        chk("R6 single vector", vecOut, val);
        wr(8'h07, ~8'(1 << i));
        rd(8'h07, d); chk("R10 zero bits keep", d, 32'(1 << i));
        wr(8'h07, 8'(1 << i));
        rd(8'h07, d); chk("R10 clear", d, 0);
      end
    end

    // R3 held level does not re-latch
    clearActs(); wr(8'h0B, 8'h30);
    irqIn = 8'h08; @(negedge clk);
    wr(8'h07, 8'h08);
    repeat (3) @(negedge clk);
    rd(8'h07, d); chk("R3 no relatch", d, 0);
    irqIn = 8'h00; @(negedge clk);

    // R6 R7 R8 pair sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (i != j) begin
          logic [7:0] a, b;
          int win, los;
          a = 8'(2 + ((i * 3 + j * 5) % 4) * 32);
          b = 8'(2 + ((j * 3 + i * 7) % 4) * 32);
          if (a < b || (a == b && i < j)) begin win = i; los = j; end
          else begin win = j; los = i; end
          clearActs();
          wr(8'(8 + i), a); wr(8'(8 + j), b);
          irqIn = 8'(1 << i) | 8'(1 << j); @(negedge clk);
          irqIn = 8'h00;
          chk("R6 pair vector", vecOut, (win == i) ? a : b);
          pulse(intAck);
          chk("R7 held off", intReq, 0);
          rd(8'h07, d); chk("R7 winner cleared", d, 32'(1 << los));
          pulse(retStrobe);
          chk("R8 intReq again", intReq, 1);
          chk("R8 next vector", vecOut, (los == i) ? a : b);
          pulse(intAck);
          pulse(retStrobe);
          rd(8'h07, d); chk("R7 all served", d, 0);
        end
      end
    end

    // R5 R9 NMI path
    clearActs();
    wr(8'h0A, 8'h01); wr(8'h0D, 8'h40);
    irqIn = 8'h24; @(negedge clk); irqIn = 8'h00;
    chk("R5 nmiReq", nmiReq, 1);
    chk("R5 maskable vector", vecOut, 8'h40);
    pulse(intAck);
    chk("R9 nmi during service", nmiReq, 1);
    chk("R7 intReq low", intReq, 0);
    pulse(nmiAck);
    chk("R5 nmi cleared", nmiReq, 0);
    rd(8'h07, d); chk("R5 pending after", d, 0);
    pulse(retStrobe);
    chk("R8 idle", intReq, 0);

    clearActs();
    wr(8'h09, 8'h01); wr(8'h0E, 8'h01);
    irqIn = 8'h42; @(negedge clk); irqIn = 8'h00;
    chk("R5 nmi only no intReq", intReq, 0);
    pulse(nmiAck);
    rd(8'h07, d); chk("R5 lowest nmi first", d, 8'h40);
    chk("R5 nmi still", nmiReq, 1);
    pulse(nmiAck);
    chk("R5 nmi done", nmiReq, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule